// File: doc/BRIEF.md
# CAN Controller Sleep and Wake Sequencer

This block moves a CAN protocol controller into and out of a low-power sleep state. Software raises a sleep request. The block answers with an acknowledge only when the bus is quiet and no transmission is running. The acknowledge is given on a bit-time boundary. While both bits are set, the controller is asleep. In that state the block gates the protocol core clock off, holds the transmit pin recessive and feeds the core a constant recessive receive level. It also holds back deferred receive-buffer copies, pending transmissions and aborts.

There are two ways out of sleep. Software can clear the request after the acknowledge has been given. A dominant bus level can also wake the block, but only if wake-up was enabled at the moment sleep began. After any wake-up the core may rejoin the bus only once it has seen a run of recessive bits. For that reason the frame that woke the block is lost. The block also holds the bus-off recovery counter. That counter pauses during sleep and resumes from its held value afterwards.

Top module: `can_slp_top`

## Requirements
- R1: `slp_req` is set by a pulse on `sw_req_set`. `slp_ack` rises only at a clock edge where `slp_req`=1, `bit_tick`=1, `tx_busy`=0 and `bus_join`=1. Sleep means `slp_req`=1 and `slp_ack`=1.
- R2: A pulse on `sw_req_clr` while `slp_ack`=0 is ignored, and `slp_req` stays 1.
- R3: While asleep, `core_clk_en`=0, `tx_pin`=1 (recessive), `rx_core`=1, `rx_copy_en`=0 and `tx_go_en`=0. All of these are released when sleep ends.
- R4: `sw_wake_en` is sampled at the edge where `slp_ack` rises. If the sampled value is 0, dominant levels (`rx_raw`=0) never end sleep.
- R5: If the sampled wake enable is 1, a dominant level ends sleep. `rx_raw` passes through a two-flop synchroniser, so both `slp_req` and `slp_ack` clear at the third rising edge after `rx_raw` goes low.
- R6: A pulse on `sw_req_clr` while `slp_ack`=1 clears both `slp_req` and `slp_ack` at the next edge.
- R7: `bus_join` (and with it `tx_go_en`) rises only after 11 consecutive `bit_tick` samples of a recessive synchronised line, counted since reset or since sleep ended. A dominant sample restarts the count.
- R8: While `bus_off`=1, every 11 consecutive recessive tick samples advance `recov_cnt` by one. After 128 such runs `recov_done` pulses for one cycle and the count returns to 0. The count holds during sleep.
- R9: After reset, `slp_req`=0, `slp_ack`=0, `recov_cnt`=0, `bus_join`=0 and `core_clk_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock (kept running in sleep) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe at each bit-time boundary |
| sw_req_set | input | 1 | Software write of 1 to the sleep request |
| sw_req_clr | input | 1 | Software write of 0 to the sleep request |
| sw_wake_en | input | 1 | Wake-on-bus-activity enable bit |
| rx_raw | input | 1 | Raw receive line, 1 = recessive |
| tx_core | input | 1 | Transmit level from the protocol core |
| tx_busy | input | 1 | Core is transmitting a frame |
| bus_off | input | 1 | Core is in bus-off state |
| slp_req | output | 1 | Sleep request status |
| slp_ack | output | 1 | Sleep acknowledge status |
| core_clk_en | output | 1 | Clock enable for the protocol core |
| rx_core | output | 1 | Receive level presented to the core |
| tx_pin | output | 1 | Transmit pin level |
| bus_join | output | 1 | Bus idle seen; core may take part |
| rx_copy_en | output | 1 | Background-to-foreground copy allowed |
| tx_go_en | output | 1 | Pending transmissions and aborts allowed |
| recov_cnt | output | 7 | Completed recessive runs during bus-off |
| recov_done | output | 1 | One-cycle pulse when recovery finishes |
| wake_evt | output | 1 | Dominant level seen while asleep with wake enabled |

## Verification
Some properties are checked on every clock edge. These are the coupling between acknowledge and request, the refusal to drop a request that has not been acknowledged, and the lock-in when wake is disabled. Also checked each cycle are the gated outputs during sleep, the conditions under which the acknowledge may rise, the recessive sample behind each rise of `bus_join`, and the frozen recovery count.

Other behaviour can only be shown by the bench's scenarios. These cover the exact latency of a bus-driven wake through the synchroniser and the sampling of the wake enable at entry rather than later. They also cover the loss of the waking frame, which shows up as a new 11-bit wait, and the total of 1408 active ticks before recovery completes across a sleep interval.

// File: rtl/can_slp_pkg.sv
package can_slp_pkg;
  localparam int unsigned IDLE_BITS_DEF = 11;
  localparam int unsigned RECOV_OCC_DEF = 128;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic req;
    logic ack;
    logic wake_lat;
  } hs_state_t;
endpackage

// File: rtl/can_slp_sync.sv
module can_slp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= ff_d;
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/can_slp_hshk.sv
module can_slp_hshk
  import can_slp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic wake_en,
  input  logic grant,
  input  logic rx_s,
  output logic req,
  output logic ack,
  output logic wake_lat,
  output logic wake_evt
);
  hs_state_t st_q, st_d;
  logic leave_sw;

  always_comb begin
    st_d     = st_q;
    leave_sw = st_q.ack & clr_req;
    wake_evt = st_q.ack & st_q.wake_lat & ~rx_s;
    if (st_q.ack) begin
      if (leave_sw || wake_evt) st_d = '0;
    end else if (st_q.req) begin
      if (grant) begin
        st_d.ack      = 1'b1;
        st_d.wake_lat = wake_en;
      end
    end else if (set_req) begin
      st_d.req = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign req      = st_q.req;
  assign ack      = st_q.ack;
  assign wake_lat = st_q.wake_lat;

  assert_ack_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.ack |-> st_q.req);
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.req && !st_q.ack) |=> st_q.req);
  assert_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.ack && !st_q.wake_lat && !clr_req) |=> st_q.ack);
endmodule

// File: rtl/can_slp_idle.sv
module can_slp_idle #(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic clr,
  output logic done
);
  localparam int unsigned CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] CMAX = CW'(IDLE_BITS);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      if (!rx)                cnt_d = '0;
      else if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == CMAX);

  assert_join_after_recessive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tick && rx && !clr));
endmodule

// File: rtl/can_slp_busoff.sv
module can_slp_busoff #(
  parameter int unsigned IDLE_BITS = 11,
  parameter int unsigned RECOV_OCC = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         rx,
  input  logic                         bus_off,
  input  logic                         hold,
  output logic [$clog2(RECOV_OCC)-1:0] occ,
  output logic                         done
);
  localparam int unsigned SW = $clog2(IDLE_BITS);
  localparam int unsigned OW = $clog2(RECOV_OCC);
  localparam logic [SW-1:0] SEQ_LAST = SW'(IDLE_BITS - 1);
  localparam logic [OW-1:0] OCC_LAST = OW'(RECOV_OCC - 1);

  logic [SW-1:0] seq_q, seq_d;
  logic [OW-1:0] occ_q, occ_d;
  logic          done_q, done_d;
  logic          step_en;

  assign step_en = bus_off & ~hold & tick;

  always_comb begin
    seq_d  = seq_q;
    occ_d  = occ_q;
    done_d = 1'b0;
    if (!bus_off) begin
      seq_d = '0;
      occ_d = '0;
    end else if (step_en) begin
      if (!rx) begin
        seq_d = '0;
      end else if (seq_q == SEQ_LAST) begin
        seq_d = '0;
        if (occ_q == OCC_LAST) begin
          occ_d  = '0;
          done_d = 1'b1;
        end else begin
          occ_d = occ_q + 1'b1;
        end
      end else begin
        seq_d = seq_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= '0;
      occ_q  <= '0;
      done_q <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      occ_q  <= occ_d;
      done_q <= done_d;
    end
  end

  assign occ  = occ_q;
  assign done = done_q;

  assert_frozen_in_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && hold) |=> ($stable(occ_q) && !done_q));
endmodule

// File: rtl/can_slp_top.sv
module can_slp_top
  import can_slp_pkg::*;
#(
  parameter int unsigned IDLE_BITS   = IDLE_BITS_DEF,
  parameter int unsigned RECOV_OCC   = RECOV_OCC_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bit_tick,
  input  logic                         sw_req_set,
  input  logic                         sw_req_clr,
  input  logic                         sw_wake_en,
  input  logic                         rx_raw,
  input  logic                         tx_core,
  input  logic                         tx_busy,
  input  logic                         bus_off,
  output logic                         slp_req,
  output logic                         slp_ack,
  output logic                         core_clk_en,
  output logic                         rx_core,
  output logic                         tx_pin,
  output logic                         bus_join,
  output logic                         rx_copy_en,
  output logic                         tx_go_en,
  output logic [$clog2(RECOV_OCC)-1:0] recov_cnt,
  output logic                         recov_done,
  output logic                         wake_evt
);
  logic rx_s;
  logic asleep;
  logic grant;
  logic wake_lat;

  can_slp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_raw), .q(rx_s)
  );

  assign grant = bit_tick & ~tx_busy & bus_join;

  can_slp_hshk u_hshk (
    .clk(clk), .rst_n(rst_n),
    .set_req(sw_req_set), .clr_req(sw_req_clr), .wake_en(sw_wake_en),
    .grant(grant), .rx_s(rx_s),
    .req(slp_req), .ack(slp_ack), .wake_lat(wake_lat), .wake_evt(wake_evt)
  );

  assign asleep = slp_req & slp_ack;

  can_slp_idle #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .rx(rx_s),
    .clr(asleep), .done(bus_join)
  );

  can_slp_busoff #(.IDLE_BITS(IDLE_BITS), .RECOV_OCC(RECOV_OCC)) u_busoff (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .rx(rx_s),
    .bus_off(bus_off), .hold(asleep), .occ(recov_cnt), .done(recov_done)
  );

  assign core_clk_en = ~asleep;
  assign rx_core     = asleep ? 1'b1 : rx_s;
  assign tx_pin      = asleep ? 1'b1 : tx_core;
  assign rx_copy_en  = ~asleep;
  assign tx_go_en    = ~asleep & bus_join;

  assert_sleep_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slp_ack |-> (!core_clk_en && tx_pin && rx_core && !tx_go_en && !rx_copy_en));
  assert_ack_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slp_ack) |-> $past(bit_tick && !tx_busy && bus_join && slp_req));
  assert_join_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slp_ack |=> !bus_join);
endmodule

// File: tb/can_slp_top_bench.sv
module can_slp_top_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic bit_tick, sw_req_set, sw_req_clr, sw_wake_en, rx_raw, tx_core, tx_busy, bus_off;
  logic slp_req, slp_ack, core_clk_en, rx_core, tx_pin, bus_join, rx_copy_en, tx_go_en;
  logic recov_done, wake_evt;
  logic [6:0] recov_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  int act     = 0;

  always #5 clk = ~clk;

  can_slp_top u_can_slp_top (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sw_req_set(sw_req_set),
    .sw_req_clr(sw_req_clr), .sw_wake_en(sw_wake_en), .rx_raw(rx_raw),
    .tx_core(tx_core), .tx_busy(tx_busy), .bus_off(bus_off),
    .slp_req(slp_req), .slp_ack(slp_ack), .core_clk_en(core_clk_en),
    .rx_core(rx_core), .tx_pin(tx_pin), .bus_join(bus_join),
    .rx_copy_en(rx_copy_en), .tx_go_en(tx_go_en), .recov_cnt(recov_cnt),
    .recov_done(recov_done), .wake_evt(wake_evt)
  );

  // vector: [7]set [6]clr [5]wake_en [4]rx [3]tx_busy [2]exp_req [1]exp_ack [0]exp_rx_core
  localparam logic [7:0] VEC [9] = '{
    8'b0101_0001, 8'b1001_1101, 8'b0001_1101, 8'b0101_1101,
    8'b0001_0111, 8'b0010_0111, 8'b0010_0111, 8'b0010_0111,
    8'b0111_0000
  };

  task automatic check(input string rq, input int actual, input int expv);
    n_tests++;
    if (actual != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, actual, expv);
    end
  endtask

  task automatic step;
    if (bit_tick && bus_off && rx_raw && !slp_ack) act++;
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    bit_tick = 1'b1; sw_req_set = 1'b0; sw_req_clr = 1'b0; sw_wake_en = 1'b0;
    rx_raw = 1'b1; tx_core = 1'b1; tx_busy = 1'b0; bus_off = 1'b0;
    act = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic enter_sleep(input logic wen);
    sw_wake_en = wen; sw_req_set = 1'b1; step();
    sw_req_set = 1'b0; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset values
    check("R9 req", slp_req, 0);
    check("R9 ack", slp_ack, 0);
    check("R9 clk_en", core_clk_en, 1);
    check("R9 join", bus_join, 0);
    check("R9 recov_cnt", recov_cnt, 0);
    // R7 eleven recessive ticks before joining
    steps(10);
    check("R7 join after 10", bus_join, 0);
    step();
    check("R7 join after 11", bus_join, 1);
    check("R7 tx_go_en", tx_go_en, 1);
    steps(2);

    // table walk: R1 R2 R3 R4 R6
    for (int i = 0; i < 9; i++) begin
      sw_req_set = VEC[i][7]; sw_req_clr = VEC[i][6]; sw_wake_en = VEC[i][5];
      rx_raw = VEC[i][4]; tx_busy = VEC[i][3];
      step();
      check($sformatf("R1/R2/R6 row%0d req", i), slp_req, VEC[i][2]);
      check($sformatf("R1/R4/R6 row%0d ack", i), slp_ack, VEC[i][1]);
      check($sformatf("R3 row%0d clk_en", i), core_clk_en, !VEC[i][1]);
      check($sformatf("R3/R4 row%0d rx_core", i), rx_core, VEC[i][0]);
    end
    sw_req_clr = 1'b0; rx_raw = 1'b1;
    steps(15);
    check("R7 rejoin after sw wake", bus_join, 1);

    // R5 wake on bus activity
    enter_sleep(1'b1);
    check("R5 asleep", slp_ack, 1);
    rx_raw = 1'b0;
    step(); check("R5 edge1 ack", slp_ack, 1);
    step(); check("R5 edge2 ack", slp_ack, 1);
    step(); check("R5 edge3 ack", slp_ack, 0);
    check("R5 edge3 req", slp_req, 0);
    check("R7 no join at wake", bus_join, 0);
    rx_raw = 1'b1;
    steps(5);
    check("R7 tx held after frame wake", tx_go_en, 0);
    steps(20);
    check("R7 join after idle", bus_join, 1);

    // R4 locked in sleep when wake disabled; R3 gated outputs
    enter_sleep(1'b0);
    sw_wake_en = 1'b1; rx_raw = 1'b0; tx_core = 1'b0;
    steps(20);
    check("R4 still asleep", slp_ack, 1);
    check("R4 rx_core recessive", rx_core, 1);
    check("R3 tx_pin recessive", tx_pin, 1);
    check("R3 copy held", rx_copy_en, 0);
    check("R3 tx held", tx_go_en, 0);
    sw_req_clr = 1'b1; step(); sw_req_clr = 1'b0;
    check("R6 clear exits", slp_ack, 0);
    check("R3 copy released", rx_copy_en, 1);
    check("R3 tx_pin follows core", tx_pin, 0);
    rx_raw = 1'b1; tx_core = 1'b1;
    steps(15);

    // R1 acknowledge waits for bit boundary
    bit_tick = 1'b0;
    sw_req_set = 1'b1; step(); sw_req_set = 1'b0;
    steps(3);
    check("R1 no ack without tick", slp_ack, 0);
    bit_tick = 1'b1; step();
    check("R1 ack on tick", slp_ack, 1);
    sw_req_clr = 1'b1; step(); sw_req_clr = 1'b0;

    // R8 bus-off recovery frozen across sleep
    do_reset();
    bus_off = 1'b1;
    steps(100);
    enter_sleep(1'b0);
    check("R8 asleep", slp_ack, 1);
    check("R8 count at entry", recov_cnt, (act / 11) % 128);
    begin
      int held;
      held = recov_cnt;
      steps(40);
      check("R8 count held", recov_cnt, held);
    end
    sw_req_clr = 1'b1; step(); sw_req_clr = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 3000 && !seen; i++) begin
        step();
        if (recov_done) seen = 1;
      end
      check("R8 done seen", seen, 1);
      check("R8 active ticks", act, 1408);
      check("R8 count wraps", recov_cnt, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule